// File: doc/BRIEF.md
# User Refresh Request Arbiter

This block sits ahead of the DRAM command issue stage of a multi-rank memory controller. It decides each cycle which single command reaches a simple command port. The candidates are user-requested refreshes, self-refresh entry and exit for individual ranks, and reads and writes offered by a command queue. A user holds a refresh request together with a per-rank select mask. The block issues a REFRESH to those ranks and pulses an acknowledge once the ranks' busy time has expired. If the request is still held, it repeats, up to a fixed burst cap.

Rank timing is reduced to one busy counter of a fixed parameter length, started by every REFRESH. Self-refresh is controlled by a per-rank level input: a high bit asks for that rank to enter, a low bit asks for it to leave. A user refresh and a self-refresh never touch the same rank at the same time. The block holds back whichever of the two arrives second.

Top module: `user_refresh_arb`

## Requirements
- R1: After reset, cmdValid, refAck and srAck are low, and qReady is high while no request is present.
- R2: While a refresh request with a non-zero select is pending and below the burst cap, or while a refresh is busy or acknowledging, qReady is low and no read (op 4) or write (op 5) reaches the command port.
- R3: The command port carries one command per cycle with op codes 0 idle, 1 REFRESH, 2 self-refresh entry, 3 self-refresh exit, 4 read, 5 write. cmdRank is the per-rank target mask, bit i for rank i. A REFRESH targets exactly the refSel bits given with the request.
- R4: refAck is a one-cycle pulse that rises REF_BUSY cycles after the cycle in which the REFRESH is shown on the command port. Another REFRESH may issue no earlier than the cycle after the acknowledge.
- R5: A request held high yields one REFRESH and one acknowledge per busy period, at most MAX_BURST (9) in a row. Further refreshes resume only after the request has been low for at least one cycle.
- R6: A request with an all-zero refSel raises refSelErr in the same cycle. It issues no command, produces no acknowledge and does not stall the queue.
- R7: A REFRESH is held off while any selected rank is in self-refresh or has its self-refresh request high. A self-refresh entry for a rank under an active refresh waits until that refresh has been acknowledged.
- R8: srAck is high while at least one rank is in self-refresh and low once no rank remains in it.
- R9: Self-refresh entry is issued, one command covering all eligible ranks, for ranks whose srReq bit is high and that are not yet in self-refresh. Exit is issued for ranks in self-refresh whose bit is low. The priority is REFRESH, then entry, then exit, then the queue.
- R10: A queue command accepted on a clock edge (qValid and qReady high) appears on the command port in the next cycle, even when a refresh request rises right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| refReq | input | 1 | User refresh request, held for repeated refreshes |
| refSel | input | NUM_RANKS | Ranks to refresh |
| refAck | output | 1 | One-cycle pulse per completed refresh |
| refSelErr | output | 1 | Request present with an empty select mask |
| srReq | input | NUM_RANKS | Per-rank self-refresh request level |
| srAck | output | 1 | At least one rank is in self-refresh |
| qValid | input | 1 | Queue offers a command |
| qWrite | input | 1 | Offered command is a write (else a read) |
| qRank | input | NUM_RANKS | Target mask of the offered command |
| qReady | output | 1 | Queue command is accepted this cycle |
| cmdValid | output | 1 | Command port holds a command |
| cmdOp | output | 3 | Command op code |
| cmdRank | output | NUM_RANKS | Command target mask |

## Verification
The bench builds the block with two ranks and a busy length of 4 cycles, and keeps the burst cap at its default of 9. With the short busy time, a full capped burst, its release and a restart all fit in a couple of hundred cycles. With two ranks, the bench can put one rank in self-refresh while the other stays free, and can exercise partial exit with srAck held. It can also show that a refresh on the shared rank waits in both directions of the conflict.

// File: rtl/user_refresh_arb_pkg.sv
package user_refresh_arb_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_REF = 3'd1,
    OP_SRE = 3'd2,
    OP_SRX = 3'd3,
    OP_RD  = 3'd4,
    OP_WR  = 3'd5
  } cmdOp_e;

  typedef struct packed {
    logic issueRef;
    logic issueSre;
    logic issueSrx;
    logic issueQ;
    logic clrBurst;
  } strobe_t;

endpackage

// File: rtl/user_refresh_arb_ctrl.sv
module user_refresh_arb_ctrl
  import user_refresh_arb_pkg::*;
#(
  parameter int NUM_RANKS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 refReq,
  input  logic [NUM_RANKS-1:0] refSel,
  input  logic [NUM_RANKS-1:0] srReq,
  input  logic                 qValid,
  input  logic                 refBusy,
  input  logic                 refAck,
  input  logic                 capped,
  input  logic [NUM_RANKS-1:0] inSr,
  input  logic [NUM_RANKS-1:0] activeRefMask,
  output strobe_t              st,
  output logic [NUM_RANKS-1:0] srMask,
  output logic                 qReady,
  output logic                 refSelErr
);

  logic                 selNonZero;
  logic                 refWant;
  logic                 refIdle;
  logic [NUM_RANKS-1:0] srOwned;
  logic [NUM_RANKS-1:0] entering;
  logic [NUM_RANKS-1:0] exiting;

  assign selNonZero = |refSel;
  assign refSelErr  = refReq && !selNonZero;
  assign refWant    = refReq && selNonZero && !capped;
  assign refIdle    = !refBusy && !refAck;
  assign srOwned    = inSr | srReq;
  assign entering   = srReq & ~inSr & ~activeRefMask;
  assign exiting    = inSr & ~srReq;

  always_comb begin
    st          = '0;
    srMask      = '0;
    st.clrBurst = !refReq;
    st.issueRef = refWant && refIdle && ((refSel & srOwned) == '0);
    if (!st.issueRef && (entering != '0)) begin
      st.issueSre = 1'b1;
      srMask      = entering;
    end else if (!st.issueRef && (exiting != '0)) begin
      st.issueSrx = 1'b1;
      srMask      = exiting;
    end
    qReady    = !refWant && refIdle && (entering == '0) && (exiting == '0);
    st.issueQ = qValid && qReady;
  end

  // R6
  sel_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    refSelErr |-> !st.issueRef);

  // R5
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    capped |-> !st.issueRef);

endmodule

// File: rtl/user_refresh_arb_dp.sv
module user_refresh_arb_dp
  import user_refresh_arb_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int REF_BUSY  = 8,
  parameter int MAX_BURST = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              st,
  input  logic [NUM_RANKS-1:0] srMask,
  input  logic [NUM_RANKS-1:0] refSel,
  input  logic                 qWrite,
  input  logic [NUM_RANKS-1:0] qRank,
  output logic                 refBusy,
  output logic                 refAck,
  output logic                 capped,
  output logic [NUM_RANKS-1:0] inSr,
  output logic [NUM_RANKS-1:0] activeRefMask,
  output logic                 cmdValid,
  output logic [2:0]           cmdOp,
  output logic [NUM_RANKS-1:0] cmdRank
);

  localparam int BW = $clog2(REF_BUSY + 1);
  localparam int CW = $clog2(MAX_BURST + 1);

  logic [BW-1:0]        busyCnt;
  logic [CW-1:0]        burstCnt;
  logic [NUM_RANKS-1:0] refMask;

  assign refBusy       = (busyCnt != '0);
  assign capped        = (burstCnt == CW'(MAX_BURST));
  assign activeRefMask = refBusy ? refMask : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt  <= '0;
      refAck   <= 1'b0;
      refMask  <= '0;
      burstCnt <= '0;
    end else begin
      if (st.issueRef)      busyCnt <= BW'(REF_BUSY);
      else if (refBusy)     busyCnt <= busyCnt - 1'b1;
      refAck <= (busyCnt == BW'(1));
      if (st.issueRef)      refMask <= refSel;
      if (st.clrBurst)      burstCnt <= '0;
      else if (st.issueRef) burstCnt <= burstCnt + 1'b1;
    end
  end

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    always_ff @(posedge clk) begin
      if (!rstN)                         inSr[r] <= 1'b0;
      else if (st.issueSre && srMask[r]) inSr[r] <= 1'b1;
      else if (st.issueSrx && srMask[r]) inSr[r] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdOp    <= OP_NOP;
      cmdRank  <= '0;
    end else begin
      cmdValid <= st.issueRef || st.issueSre || st.issueSrx || st.issueQ;
      if (st.issueRef) begin
        cmdOp <= OP_REF;  cmdRank <= refSel;
      end else if (st.issueSre) begin
        cmdOp <= OP_SRE;  cmdRank <= srMask;
      end else if (st.issueSrx) begin
        cmdOp <= OP_SRX;  cmdRank <= srMask;
      end else if (st.issueQ) begin
        cmdOp <= qWrite ? OP_WR : OP_RD;  cmdRank <= qRank;
      end else begin
        cmdOp <= OP_NOP;  cmdRank <= '0;
      end
    end
  end

  // R4
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    refAck |=> !refAck);

  // R4
  ref_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.issueRef |-> (!refBusy && !refAck));

  // R2
  queue_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    refBusy |=> !(cmdValid && (cmdOp == OP_RD || cmdOp == OP_WR)));

  // R5
  burst_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstCnt <= CW'(MAX_BURST));

  // R7
  ref_sr_clash_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_REF) |-> ((cmdRank & inSr) == '0));

  // R7
  sre_clash_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.issueSre |-> ((srMask & activeRefMask) == '0));

endmodule

// File: rtl/user_refresh_arb.sv
module user_refresh_arb
  import user_refresh_arb_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int REF_BUSY  = 8,
  parameter int MAX_BURST = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 refReq,
  input  logic [NUM_RANKS-1:0] refSel,
  output logic                 refAck,
  output logic                 refSelErr,
  input  logic [NUM_RANKS-1:0] srReq,
  output logic                 srAck,
  input  logic                 qValid,
  input  logic                 qWrite,
  input  logic [NUM_RANKS-1:0] qRank,
  output logic                 qReady,
  output logic                 cmdValid,
  output logic [2:0]           cmdOp,
  output logic [NUM_RANKS-1:0] cmdRank
);

  strobe_t              st;
  logic [NUM_RANKS-1:0] srMask;
  logic [NUM_RANKS-1:0] inSr;
  logic [NUM_RANKS-1:0] activeRefMask;
  logic                 refBusy;
  logic                 capped;

  assign srAck = |inSr;

  user_refresh_arb_ctrl #(.NUM_RANKS(NUM_RANKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .refReq(refReq), .refSel(refSel), .srReq(srReq),
    .qValid(qValid), .refBusy(refBusy), .refAck(refAck), .capped(capped),
    .inSr(inSr), .activeRefMask(activeRefMask), .st(st), .srMask(srMask),
    .qReady(qReady), .refSelErr(refSelErr)
  );

  user_refresh_arb_dp #(
    .NUM_RANKS(NUM_RANKS), .REF_BUSY(REF_BUSY), .MAX_BURST(MAX_BURST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .srMask(srMask), .refSel(refSel),
    .qWrite(qWrite), .qRank(qRank), .refBusy(refBusy), .refAck(refAck),
    .capped(capped), .inSr(inSr), .activeRefMask(activeRefMask),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdRank(cmdRank)
  );

  // R8
  sr_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_SRE) |-> srAck);

endmodule

// File: tb/user_refresh_arb_test.sv
`timescale 1ns/1ps
module user_refresh_arb_test;

  localparam int NR   = 2;
  localparam int BUSY = 4;
  localparam int CAP  = 9;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          refReq = 1'b0;
  logic [NR-1:0] refSel = '0;
  logic          refAck, refSelErr, srAck, qReady, cmdValid;
  logic [NR-1:0] srReq = '0;
  logic          qValid = 1'b0, qWrite = 1'b0;
  logic [NR-1:0] qRank = '0;
  logic [2:0]    cmdOp;
  logic [NR-1:0] cmdRank;

  int testsRun = 0;
  int failCnt  = 0;
  int ackCount = 0;
  logic [4:0] expQ[$];
  string      tagQ[$];

  always #10 clk = ~clk;

  user_refresh_arb #(.NUM_RANKS(NR), .REF_BUSY(BUSY), .MAX_BURST(CAP)) uut (
    .clk(clk), .rstN(rstN), .refReq(refReq), .refSel(refSel), .refAck(refAck),
    .refSelErr(refSelErr), .srReq(srReq), .srAck(srAck), .qValid(qValid),
    .qWrite(qWrite), .qRank(qRank), .qReady(qReady), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdRank(cmdRank)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pushExp(input logic [2:0] op, input logic [NR-1:0] rk, input string tag);
    expQ.push_back({op, rk});
    tagQ.push_back(tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && cmdValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R3 unexpected command", int'({cmdOp, cmdRank}), 0);
      end else begin
        logic [4:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check({cmdOp, cmdRank} == e, t, int'({cmdOp, cmdRank}), int'(e));
      end
    end
  end

  always @(negedge clk) if (rstN && refAck) ackCount++;

  task automatic waitAck(input string tag);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!refAck && n < 100);
    check(refAck, tag, 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, failCnt);
    $finish;
  end

  initial begin
    int base;
    int bad;
    int lat;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check(!cmdValid && !refAck && !srAck, "R1 reset outputs", int'({cmdValid, refAck, srAck}), 0);
    check(qReady, "R1 qReady idle", int'(qReady), 1);

    // R3 plain queue write then read
    pushExp(3'd5, 2'b01, "R3 write");
    pushExp(3'd4, 2'b10, "R3 read");
    qValid = 1; qWrite = 1; qRank = 2'b01;
    @(negedge clk);
    qWrite = 0; qRank = 2'b10;
    @(negedge clk);
    qValid = 0;
    repeat (3) @(negedge clk);

    // R4 single refresh, latency to ack
    base = ackCount;
    pushExp(3'd1, 2'b01, "R3 refresh mask");
    refReq = 1; refSel = 2'b01;
    lat = 0;
    do @(negedge clk); while (!cmdValid);
    do begin @(negedge clk); lat++; end while (!refAck && lat < 50);
    refReq = 0;
    check(lat == BUSY, "R4 ack latency", lat, BUSY);
    repeat (10) @(negedge clk);
    check(ackCount - base == 1, "R4 single ack", ackCount - base, 1);

    // R5 capped burst, R2 queue stall during burst
    base = ackCount;
    for (int i = 0; i < CAP; i++) pushExp(3'd1, 2'b11, "R5 burst refresh");
    refReq = 1; refSel = 2'b11; qValid = 1; qWrite = 0; qRank = 2'b10;
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (qReady) bad++;
    end
    check(bad == 0, "R2 qReady low while refreshing", bad, 0);
    qValid = 0;
    repeat (40) @(negedge clk);
    check(ackCount - base == CAP, "R5 burst capped at nine", ackCount - base, CAP);
    check(qReady, "R5 queue free once capped", int'(qReady), 1);
    refReq = 0;
    @(negedge clk);
    pushExp(3'd1, 2'b11, "R5 restart refresh");
    refReq = 1;
    waitAck("R5 restart ack");
    refReq = 0;
    repeat (10) @(negedge clk);
    check(ackCount - base == CAP + 1, "R5 restart count", ackCount - base, CAP + 1);

    // R6 zero select
    base = ackCount;
    refReq = 1; refSel = 2'b00;
    @(negedge clk);
    check(refSelErr, "R6 error flag", int'(refSelErr), 1);
    check(qReady, "R6 queue not stalled", int'(qReady), 1);
    repeat (20) @(negedge clk);
    check(ackCount == base, "R6 no ack", ackCount - base, 0);
    refReq = 0;
    @(negedge clk);

    // R7 refresh waits for rank in self-refresh, R9 ordering
    pushExp(3'd2, 2'b01, "R9 entry rank0");
    srReq = 2'b01;
    repeat (3) @(negedge clk);
    check(srAck, "R8 srAck after entry", int'(srAck), 1);
    base = ackCount;
    refReq = 1; refSel = 2'b01;
    repeat (20) @(negedge clk);
    check(ackCount == base, "R7 refresh held on self-refresh rank", ackCount - base, 0);
    pushExp(3'd3, 2'b01, "R9 exit rank0");
    pushExp(3'd1, 2'b01, "R7 refresh after exit");
    srReq = 2'b00;
    waitAck("R7 ack after exit");
    refReq = 0;
    repeat (3) @(negedge clk);
    check(!srAck, "R8 srAck cleared", int'(srAck), 0);

    // R7 self-refresh entry waits for active refresh
    pushExp(3'd1, 2'b01, "R7 refresh first");
    pushExp(3'd2, 2'b01, "R7 entry after ack");
    pushExp(3'd3, 2'b01, "R9 exit after entry");
    refReq = 1; refSel = 2'b01;
    do @(negedge clk); while (!cmdValid);
    refReq = 0; srReq = 2'b01;
    bad = 0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (cmdValid) bad++;
    end while (!refAck && lat < 50);
    check(bad == 0, "R7 entry deferred during refresh", bad, 0);
    repeat (3) @(negedge clk);
    check(srAck, "R8 srAck after deferred entry", int'(srAck), 1);
    srReq = 2'b00;
    repeat (3) @(negedge clk);

    // R8 partial exit keeps srAck
    pushExp(3'd2, 2'b11, "R9 entry both ranks");
    pushExp(3'd3, 2'b10, "R9 exit rank1");
    pushExp(3'd3, 2'b01, "R9 exit rank0");
    srReq = 2'b11;
    repeat (3) @(negedge clk);
    srReq = 2'b01;
    repeat (3) @(negedge clk);
    check(srAck, "R8 srAck held with one rank", int'(srAck), 1);
    srReq = 2'b00;
    repeat (3) @(negedge clk);
    check(!srAck, "R8 srAck low with none", int'(srAck), 0);

    // R10 accepted command survives a following refresh request
    pushExp(3'd4, 2'b10, "R10 accepted read");
    pushExp(3'd1, 2'b01, "R10 refresh after read");
    qValid = 1; qWrite = 0; qRank = 2'b10;
    @(negedge clk);
    qValid = 0; refReq = 1; refSel = 2'b01;
    check(cmdValid && cmdOp == 3'd4, "R10 read on port", int'(cmdOp), 4);
    waitAck("R10 refresh ack");
    refReq = 0;
    repeat (10) @(negedge clk);

    check(expQ.size() == 0, "R3 all expected commands seen", expQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, failCnt);
    $finish;
  end

endmodule